// File: doc/BRIEF.md
# Line-Scan Test Pattern Generator

This block sits in a line-scan camera's pixel path. It either forwards live sensor pixels or replaces them with synthetic lines of known content. The synthetic content can be a horizontal ramp, a full-scale white line, a mid-scale grey line, a black line, or a vertical ramp that keeps one level across each line and steps up from one line to the next. Every generated code is limited to the selected pixel depth of 8, 10 or 12 bits.

A line is requested with a single-cycle trigger. On that edge the block samples the pattern selection, the pixel format code and the line width, and holds them for the whole line. It then emits one pixel per clock, with start-of-line and end-of-line markers. When the sampled selection is "off", live input is forwarded with its markers after one register stage.

Top module: `linepat_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted line, out_valid, out_sol and out_eol are 0 and out_data is 0 for zero live input. The active selection is "off" (pass-through). The vertical ramp level is 0.
- R2: Selection codes on cfg_pattern: 0 off, 1 horizontal ramp, 2 white, 3 grey, 4 black, 5 vertical ramp. Codes 6 and 7 behave exactly like 0.
- R3: Format codes on cfg_format: 16'h0101 selects 8 bits (maximum 255), 16'h0102 selects 10 bits (maximum 1023), 16'h0103 selects 12 bits (maximum 4095). Any other code selects 8 bits. A generated code never exceeds the maximum.
- R4: A line is accepted when line_trig is 1, no generated line is in progress and cfg_width is nonzero. For a pattern selection, the first pixel is on the outputs right after the edge that samples the trigger, with out_sol 1. The remaining pixels follow on consecutive edges, cfg_width pixels in total, and out_eol is 1 on the last one. Between generated lines out_valid is 0.
- R5: While a generated line is in progress, line_trig is ignored. Changes to cfg_pattern, cfg_format and cfg_width have no effect until the next accepted line.
- R6: For the horizontal ramp, pixel i of a line carries i modulo (maximum + 1).
- R7: White carries the maximum code, black carries 0, and grey carries (maximum + 1) / 2, that is 128, 512 or 2048.
- R8: A vertical-ramp line carries one level on all its pixels. The first such line after reset carries 0. Each later vertical-ramp line carries the previous level plus one, wrapping to 0 after the maximum. Lines of other patterns leave the level unchanged.
- R9: With "off" active and no line in progress, out_valid, out_data, out_sol and out_eol equal in_valid, in_data, in_sol and in_eol one edge earlier, unchanged. While a pattern selection is active, live input is ignored.
- R10: A trigger with cfg_width equal to 0 is ignored: no line starts and no configuration is sampled.
- R11: A line of width 1 is a single pixel with out_sol and out_eol both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pattern | input | 3 | Pattern selection code |
| cfg_format | input | 16 | Pixel format code |
| cfg_width | input | 15 | Line width in pixels, 1 to MAX_WIDTH |
| line_trig | input | 1 | Line request pulse |
| in_valid | input | 1 | Live pixel valid |
| in_data | input | 12 | Live pixel code |
| in_sol | input | 1 | Live start-of-line marker |
| in_eol | input | 1 | Live end-of-line marker |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 12 | Output pixel code |
| out_sol | output | 1 | Output start-of-line marker |
| out_eol | output | 1 | Output end-of-line marker |

## Verification
A generated line's first pixel is due on the same edge that samples an accepted trigger, and pixel i is due i edges later. The idle gap (out_valid low) is due on the edge after the end-of-line pixel. Forwarded live pixels are due one edge after they are presented. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each read falls exactly one rising edge after the stimulus it checks, and a line is read as one result per falling edge starting right after the trigger.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;

  localparam int PIX_W = 12;

  typedef enum logic [2:0] {
    PAT_OFF   = 3'd0,
    PAT_HRAMP = 3'd1,
    PAT_WHITE = 3'd2,
    PAT_GREY  = 3'd3,
    PAT_BLACK = 3'd4,
    PAT_VRAMP = 3'd5
  } pat_e;

  typedef enum logic [1:0] {
    DEP_8  = 2'd0,
    DEP_10 = 2'd1,
    DEP_12 = 2'd2
  } dep_e;

  localparam logic [15:0] FMT_MONO8  = 16'h0101;
  localparam logic [15:0] FMT_MONO10 = 16'h0102;
  localparam logic [15:0] FMT_MONO12 = 16'h0103;

  // Largest code of a depth; also the wrap mask of both ramps.
  function automatic logic [PIX_W-1:0] dep_max(input dep_e d);
    case (d)
      DEP_10:  dep_max = PIX_W'(12'h3FF);
      DEP_12:  dep_max = PIX_W'(12'hFFF);
      default: dep_max = PIX_W'(12'h0FF);
    endcase
  endfunction

  function automatic dep_e fmt_to_dep(input logic [15:0] f);
    case (f)
      FMT_MONO8:  fmt_to_dep = DEP_8;
      FMT_MONO10: fmt_to_dep = DEP_10;
      FMT_MONO12: fmt_to_dep = DEP_12;
      default:    fmt_to_dep = DEP_8;
    endcase
  endfunction

  function automatic pat_e sel_to_pat(input logic [2:0] s);
    case (s)
      3'd1:    sel_to_pat = PAT_HRAMP;
      3'd2:    sel_to_pat = PAT_WHITE;
      3'd3:    sel_to_pat = PAT_GREY;
      3'd4:    sel_to_pat = PAT_BLACK;
      3'd5:    sel_to_pat = PAT_VRAMP;
      default: sel_to_pat = PAT_OFF;
    endcase
  endfunction

endpackage

// File: rtl/tpg_cfg.sv
`timescale 1ns/1ps
// Decodes the raw selection and format codes and holds them per line.
module tpg_cfg
  import tpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [2:0]  sel_raw,
  input  logic [15:0] fmt_raw,
  output pat_e        pat_d,
  output dep_e        dep_d,
  output pat_e        pat_q,
  output dep_e        dep_q
);

  always_comb begin
    pat_d = sel_to_pat(sel_raw);
    dep_d = fmt_to_dep(fmt_raw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= PAT_OFF;
      dep_q <= DEP_8;
    end else if (load) begin
      pat_q <= pat_d;
      dep_q <= dep_d;
    end
  end

endmodule

// File: rtl/tpg_vramp.sv
`timescale 1ns/1ps
// Line-to-line level of the moving vertical ramp.
module tpg_vramp
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [PIX_W-1:0] mask,
  output logic [PIX_W-1:0] start_val,
  output logic [PIX_W-1:0] line_val
);

  logic [PIX_W-1:0] nxt_q;
  logic [PIX_W-1:0] nxt_d;

  always_comb begin
    start_val = nxt_q & mask;
    nxt_d     = (start_val + PIX_W'(1)) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q    <= '0;
      line_val <= '0;
    end else if (adv) begin
      nxt_q    <= nxt_d;
      line_val <= start_val;
    end
  end

endmodule

// File: rtl/tpg_pixsel.sv
`timescale 1ns/1ps
// Pixel code for the current column under the active pattern.
module tpg_pixsel
  import tpg_pkg::*;
(
  input  pat_e             pat,
  input  logic [PIX_W-1:0] mask,
  input  logic [PIX_W-1:0] col_lo,
  input  logic [PIX_W-1:0] vval,
  output logic [PIX_W-1:0] pix
);

  always_comb begin
    case (pat)
      PAT_HRAMP: pix = col_lo & mask;
      PAT_WHITE: pix = mask;
      PAT_GREY:  pix = (mask >> 1) + PIX_W'(1);
      PAT_VRAMP: pix = vval;
      default:   pix = '0;
    endcase
  end

endmodule

// File: rtl/linepat_gen.sv
`timescale 1ns/1ps
module linepat_gen
  import tpg_pkg::*;
#(
  parameter int MAX_WIDTH = 16384,
  localparam int WW = $clog2(MAX_WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_pattern,
  input  logic [15:0]      cfg_format,
  input  logic [WW-1:0]    cfg_width,
  input  logic             line_trig,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sol,
  input  logic             in_eol,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sol,
  output logic             out_eol
);

  logic             start;
  logic             busy_q, busy_d;
  logic [WW-1:0]    col_q, col_d, col_use;
  logic [WW-1:0]    width_q, width_use;
  pat_e             pat_d, pat_q, pat_use;
  dep_e             dep_d, dep_q, dep_use;
  logic [PIX_W-1:0] mask, vstart, vline, vval, col_lo, pix;
  logic             gen, last;
  logic             ov_d, os_d, oe_d;
  logic [PIX_W-1:0] od_d;

  // Accept a line only between generated lines and with a nonzero width.
  assign start = line_trig & ~busy_q & (cfg_width != '0);

  tpg_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .sel_raw (cfg_pattern),
    .fmt_raw (cfg_format),
    .pat_d   (pat_d),
    .dep_d   (dep_d),
    .pat_q   (pat_q),
    .dep_q   (dep_q)
  );

  // On the accepting edge the freshly decoded settings drive pixel 0.
  always_comb begin
    pat_use   = start ? pat_d : pat_q;
    dep_use   = start ? dep_d : dep_q;
    width_use = start ? cfg_width : width_q;
    col_use   = start ? '0 : col_q;
    mask      = dep_max(dep_use);
    gen       = start ? (pat_d != PAT_OFF) : busy_q;
    last      = (col_use == width_use - WW'(1));
  end

  tpg_vramp u_vramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (start && (pat_d == PAT_VRAMP)),
    .mask      (mask),
    .start_val (vstart),
    .line_val  (vline)
  );

  assign vval = start ? vstart : vline;

  generate
    if (WW >= PIX_W) begin : g_col_trunc
      assign col_lo = col_use[PIX_W-1:0];
    end else begin : g_col_ext
      assign col_lo = {{(PIX_W - WW){1'b0}}, col_use};
    end
  endgenerate

  tpg_pixsel u_pixsel (
    .pat    (pat_use),
    .mask   (mask),
    .col_lo (col_lo),
    .vval   (vval),
    .pix    (pix)
  );

  // Next state: generate, forward live data, or stay quiet.
  always_comb begin
    busy_d = busy_q;
    col_d  = col_q;
    ov_d   = 1'b0;
    od_d   = '0;
    os_d   = 1'b0;
    oe_d   = 1'b0;
    if (gen) begin
      ov_d   = 1'b1;
      od_d   = pix;
      os_d   = (col_use == '0);
      oe_d   = last;
      busy_d = ~last;
      col_d  = col_use + WW'(1);
    end else if (pat_use == PAT_OFF) begin
      ov_d = in_valid;
      od_d = in_data;
      os_d = in_sol;
      oe_d = in_eol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else if (gen) begin
      col_q <= col_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
    end else if (start) begin
      width_q <= cfg_width;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sol   <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      out_valid <= ov_d;
      out_data  <= od_d;
      out_sol   <= os_d;
      out_eol   <= oe_d;
    end
  end

endmodule

// File: rtl/linepat_gen_chk.sv
`timescale 1ns/1ps
module linepat_gen_chk
  import tpg_pkg::*;
#(
  parameter int WW = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_pattern,
  input logic [WW-1:0]    cfg_width,
  input logic             line_trig,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_data,
  input logic             busy,
  input pat_e             pat_q,
  input dep_e             dep_q,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_data,
  input logic             out_sol
);

  assert_line_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_trig && !busy && (cfg_width != '0) && (cfg_pattern >= 3'd1) && (cfg_pattern <= 3'd5))
    |=> (out_valid && out_sol && (pat_q != PAT_OFF)));

  assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (out_valid && !out_sol));

  assert_code_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (pat_q != PAT_OFF)) |-> (out_data <= dep_max(dep_q)));

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pat_q) && $stable(dep_q)));

  assert_white_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (pat_q == PAT_WHITE)) |-> (out_data == dep_max(dep_q)));

  assert_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !line_trig && (pat_q == PAT_OFF))
    |=> ((out_valid == $past(in_valid)) && (out_data == $past(in_data))));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !line_trig && (pat_q != PAT_OFF)) |=> !out_valid);

  assert_zero_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_trig && !busy && (cfg_width == '0)) |=> ($stable(pat_q) && !busy));

endmodule

bind linepat_gen linepat_gen_chk #(.WW(WW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_pattern (cfg_pattern),
  .cfg_width   (cfg_width),
  .line_trig   (line_trig),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .busy        (busy_q),
  .pat_q       (pat_q),
  .dep_q       (dep_q),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_sol     (out_sol)
);

// File: tb/test_linepat_gen.sv
`timescale 1ns/1ps
module test_linepat_gen;

  localparam int WW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cfg_pattern;
  logic [15:0]   cfg_format;
  logic [WW-1:0] cfg_width;
  logic          line_trig;
  logic          in_valid;
  logic [11:0]   in_data;
  logic          in_sol;
  logic          in_eol;
  logic          out_valid;
  logic [11:0]   out_data;
  logic          out_sol;
  logic          out_eol;

  int checks   = 0;
  int failures = 0;
  int vnext    = 0;

  always #10 clk = ~clk;

  linepat_gen i_linepat_gen (
    .clk(clk), .rst_n(rst_n), .cfg_pattern(cfg_pattern), .cfg_format(cfg_format),
    .cfg_width(cfg_width), .line_trig(line_trig), .in_valid(in_valid), .in_data(in_data),
    .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid), .out_data(out_data),
    .out_sol(out_sol), .out_eol(out_eol)
  );

  function automatic int fmax(input logic [15:0] f);
    case (f)
      16'h0102: return 1023;
      16'h0103: return 4095;
      default:  return 255;
    endcase
  endfunction

  function automatic int exp_pix(input int pat, input logic [15:0] f, input int i, input int v);
    case (pat)
      1: return i % (fmax(f) + 1);
      2: return fmax(f);
      3: return (fmax(f) + 1) / 2;
      5: return v;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Packs valid, sol, eol and data into one comparable word.
  function automatic int pack(input bit v, input bit s, input bit e, input int d);
    return (int'(v) << 16) | (int'(s) << 15) | (int'(e) << 14) | d;
  endfunction

  task automatic chk_out(input string req, input string what, input bit v, input bit s, input bit e, input int d);
    int act;
    act = pack(out_valid, out_sol, out_eol, int'(out_data));
    chk(req, act == pack(v, s, e, d), what, act, pack(v, s, e, d));
  endtask

  // Requests one line and checks each pixel; disturb pokes trigger and config mid-line (R5).
  task automatic run_line(input int pat, input logic [15:0] f, input int w, input bit disturb, input string req);
    int v;
    v = 0;
    if (pat == 5) begin
      v = vnext & fmax(f);
      vnext = (v + 1) & fmax(f);
    end
    @(negedge clk);
    cfg_pattern = 3'(pat);
    cfg_format  = f;
    cfg_width   = WW'(w);
    line_trig   = 1'b1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (disturb) begin
        if (i == 0) begin
          cfg_pattern = 3'd2;
          cfg_format  = 16'h0101;
          cfg_width   = WW'(2);
        end
        if (i == w - 2) line_trig = 1'b0;
      end else begin
        line_trig = 1'b0;
      end
      chk_out(req, $sformatf("pat %0d pixel %0d", pat, i), 1'b1, i == 0, i == w - 1, exp_pix(pat, f, i, v));
    end
    @(negedge clk);
    chk(req, !out_valid, "gap after line", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_pattern = '0; cfg_format = 16'h0101; cfg_width = '0;
    line_trig = 1'b0; in_valid = 1'b0; in_data = '0; in_sol = 1'b0; in_eol = 1'b0;
    repeat (3) @(negedge clk);
    chk_out("R1", "outputs in reset", 1'b0, 1'b0, 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_out("R1", "outputs after reset", 1'b0, 1'b0, 1'b0, 0);
    // Off active from reset: live data forwarded with no trigger.
    in_valid = 1'b1; in_data = 12'h5A5; in_sol = 1'b1;
    @(negedge clk);
    chk_out("R1", "forward after reset", 1'b1, 1'b1, 1'b0, 12'h5A5);
    in_valid = 1'b0; in_data = '0; in_sol = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_forward(input int code, input int d1, input int d2);
    @(negedge clk);
    cfg_pattern = 3'(code); cfg_width = WW'(1); line_trig = 1'b1;
    @(negedge clk);
    line_trig = 1'b0;
    in_valid = 1'b1; in_data = 12'(d1); in_sol = 1'b1; in_eol = 1'b0;
    @(negedge clk);
    chk_out("R9", $sformatf("forward code %0d first", code), 1'b1, 1'b1, 1'b0, d1);
    in_valid = 1'b0; in_data = 12'(d2); in_sol = 1'b0; in_eol = 1'b1;
    @(negedge clk);
    chk_out("R2", $sformatf("forward code %0d second", code), 1'b0, 1'b0, 1'b1, d2);
    in_valid = 1'b0; in_data = '0; in_eol = 1'b0;
  endtask

  task automatic t_zero_width;
    @(negedge clk);
    cfg_pattern = 3'd2; cfg_width = '0; line_trig = 1'b1;
    @(negedge clk);
    line_trig = 1'b0;
    chk("R10", !out_valid, "no line on zero width", int'(out_valid), 0);
    in_valid = 1'b1; in_data = 12'h123;
    @(negedge clk);
    chk_out("R10", "still forwarding", 1'b1, 1'b0, 1'b0, 12'h123);
    in_valid = 1'b0; in_data = '0;
  endtask

  task automatic t_ignore_live;
    run_line(4, 16'h0103, 3, 1'b0, "R7");
    in_valid = 1'b1; in_data = 12'hABC; in_sol = 1'b1;
    @(negedge clk);
    chk_out("R9", "live ignored 1", 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    chk_out("R9", "live ignored 2", 1'b0, 1'b0, 1'b0, 0);
    in_valid = 1'b0; in_data = '0; in_sol = 1'b0;
  endtask

  task automatic t_vramp;
    for (int k = 0; k < 257; k++) run_line(5, 16'h0101, 2, 1'b0, "R8");
    run_line(2, 16'h0102, 2, 1'b0, "R7");
    run_line(5, 16'h0102, 3, 1'b0, "R8");
  endtask

  initial begin
    t_reset();
    t_forward(0, 12'h0F1, 12'h3C3);
    run_line(1, 16'h0101, 300, 1'b0, "R6");
    run_line(1, 16'h0102, 1030, 1'b0, "R6");
    run_line(1, 16'h0103, 4100, 1'b0, "R6");
    run_line(2, 16'h0101, 3, 1'b0, "R7");
    run_line(2, 16'h0103, 3, 1'b0, "R3");
    run_line(2, 16'h0000, 3, 1'b0, "R3");
    run_line(3, 16'h0101, 3, 1'b0, "R7");
    run_line(3, 16'h0102, 3, 1'b0, "R7");
    run_line(3, 16'h0103, 3, 1'b0, "R7");
    run_line(4, 16'h0102, 3, 1'b0, "R7");
    t_vramp();
    run_line(1, 16'h0103, 8, 1'b1, "R5");
    run_line(3, 16'h0102, 1, 1'b0, "R11");
    run_line(1, 16'h0101, 5, 1'b0, "R4");
    t_ignore_live();
    t_forward(6, 12'h777, 12'h001);
    t_forward(7, 12'hFFE, 12'h800);
    t_zero_width();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule